// File: doc/BRIEF.md
# Indexed Postbyte Address Generator

This block turns one indexed-addressing postbyte, plus up to two extension bytes, into a 16-bit effective address. Five families of encoding are decoded: a short signed constant offset, auto-modify of an index register (pre or post, step of 1 to 8 either way), an 8/9-bit or 16-bit extension offset, an accumulator offset, and two memory-indirect forms. The indirect forms fetch a 16-bit pointer over a byte-wide request/acknowledge read port. The pointer is read as two bytes, with the high byte at the computed address.

A request is a one-cycle `start` pulse that carries the postbyte, the extension bytes and the current register values. The result appears on registered outputs together with a one-cycle `done` pulse. For auto-modify, a write-back strobe also appears, with the register selector and the new value. When `restrict_mode` is high, the forms that need extension bytes or memory indirection are refused. A refused request returns address 0 and raises `reject`.

Top module: `idx_agen`

## Requirements
- R1: When postbyte bit 5 is 0, the address is the register chosen by bits 7:6 (0=X, 1=Y, 2=SP, 3=PC) plus bits 4:0 taken as a signed 5-bit value. `done` pulses in the cycle after `start`, and `extra_cycles` is 0.
- R2: When bit 5 is 1 and bits 7:6 are not 3, the request is auto-modify. If bit 3 is 1, the step is bits 3:0 sign-extended (-8..-1); otherwise the step is bits 3:0 plus 1. `wb_en` pulses with `done`, `wb_sel` is bits 7:6 and `wb_val` is the old register value plus the step.
- R3: In auto-modify, bit 4 = 0 returns the updated register value as the address, and bit 4 = 1 returns the original value.
- R4: When bits 7:6 are 3, bits 4:3 pick the register. With bit 2 = 0 and bits 2:0 not 011: bit 1 = 1 adds the 16-bit extension {ext0, ext1}, and bit 1 = 0 adds ext0 sign-extended with bit 0 as its sign. `extra_cycles` is 1.
- R5: When bits 7:6 are 3 and bits 2:0 are 100, 101 or 110, the offset added is zero-extended A, zero-extended B, or D = {A, B} respectively, and `extra_cycles` is 0.
- R6: When bits 7:6 are 3 and bits 2:0 are 011, the pointer address is the register plus {ext0, ext1}. The block reads byte address P, then P+1 (high byte first), and returns {byte(P), byte(P+1)}. `done` pulses in the cycle after the second acknowledge, and `extra_cycles` is 1.
- R7: When bits 7:6 are 3 and bits 2:0 are 111, the pointer address is the register plus D, and it is read as in R6 with `extra_cycles` 1.
- R8: With `restrict_mode` high, the forms of R4, R6 and R7 give `reject`=1, address 0, `extra_cycles` 0, no read request and no write-back. The forms of R1, R2, R3 and R5 are unaffected.
- R9: All address sums, including the P+1 pointer byte address, wrap modulo 2^16.
- R10: Once raised, `rd_req` stays high with `rd_addr` unchanged until `rd_ack` is seen.
- R11: After reset, `done`, `wb_en`, `reject`, `rd_req` and `ea` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request strobe |
| postbyte | input | 8 | Indexed mode postbyte |
| ext0 | input | 8 | First extension byte |
| ext1 | input | 8 | Second extension byte |
| restrict_mode | input | 1 | Refuse extension and indirect forms |
| x_reg | input | 16 | Index register X |
| y_reg | input | 16 | Index register Y |
| sp_reg | input | 16 | Stack pointer |
| pc_reg | input | 16 | Program counter |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| rd_req | output | 1 | Pointer byte read request |
| rd_addr | output | 16 | Pointer byte address |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | 8 | Read byte |
| done | output | 1 | Result valid pulse |
| ea | output | 16 | Effective address |
| reject | output | 1 | Postbyte refused under restriction |
| extra_cycles | output | 2 | Extra cycles charged |
| wb_en | output | 1 | Index register write-back strobe |
| wb_sel | output | 2 | Register to write back (0=X,1=Y,2=SP,3=PC) |
| wb_val | output | 16 | Write-back value |

## Verification
A wrong decode or register selection shows on `ea` in the cycle after `start`, or, for indirect forms, on the first `rd_addr`. A bad pointer-byte sequencer shows as a wrong second byte address, a wrong byte order in `ea`, or a `done` that is early or missing relative to the second acknowledge. A wrong restriction decision shows in the same result cycle: a stray `reject`, a non-zero address, or a read request that never should have started.

// File: rtl/idx_agen_pkg.sv
package idx_agen_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 2 * BYTE_W;
  localparam int RSEL_W  = 2;
  localparam int EXTRA_W = 2;

  typedef enum logic [2:0] {
    AM_CONST5, AM_AUTO, AM_OFF9, AM_OFF16, AM_IND16, AM_ACC, AM_ACCIND
  } amode_e;

  typedef struct packed {
    amode_e              mode;
    logic [RSEL_W-1:0]   rsel;
    logic [ADDR_W-1:0]   offset;
    logic                post;
    logic                indirect;
    logic                writeback;
    logic                guarded;
    logic [EXTRA_W-1:0]  extra;
  } dec_t;
endpackage

// File: rtl/idx_decode.sv
module idx_decode
  import idx_agen_pkg::*;
(
  input  logic [BYTE_W-1:0] pb,
  input  logic [BYTE_W-1:0] e0,
  input  logic [BYTE_W-1:0] e1,
  input  logic [BYTE_W-1:0] a,
  input  logic [BYTE_W-1:0] b,
  output dec_t              d
);
  localparam int CW = 5;
  localparam int SW = 4;

  always_comb begin
    d = '0;
    d.mode = AM_CONST5;
    d.rsel = pb[7:6];
    if (!pb[5]) begin
      d.mode   = AM_CONST5;
      d.offset = {{(ADDR_W-CW){pb[4]}}, pb[CW-1:0]};
    end else if (pb[7:6] != 2'b11) begin
      d.mode      = AM_AUTO;
      d.post      = pb[4];
      d.writeback = 1'b1;
      if (pb[3])
        d.offset = {{(ADDR_W-SW){1'b1}}, pb[SW-1:0]};
      else
        d.offset = {{(ADDR_W-SW){1'b0}}, pb[SW-1:0]} + 1'b1;
    end else begin
      d.rsel = pb[4:3];
      if (pb[2:0] == 3'b011) begin
        d.mode     = AM_IND16;
        d.offset   = {e0, e1};
        d.indirect = 1'b1;
        d.guarded  = 1'b1;
        d.extra    = 1;
      end else if (!pb[2]) begin
        d.guarded = 1'b1;
        d.extra   = 1;
        if (pb[1]) begin
          d.mode   = AM_OFF16;
          d.offset = {e0, e1};
        end else begin
          d.mode   = AM_OFF9;
          d.offset = {{(ADDR_W-BYTE_W){pb[0]}}, e0};
        end
      end else begin
        case (pb[1:0])
          2'b00:   begin d.mode = AM_ACC; d.offset = {{(ADDR_W-BYTE_W){1'b0}}, a}; end
          2'b01:   begin d.mode = AM_ACC; d.offset = {{(ADDR_W-BYTE_W){1'b0}}, b}; end
          2'b10:   begin d.mode = AM_ACC; d.offset = {a, b}; end
          default: begin
            d.mode     = AM_ACCIND;
            d.offset   = {a, b};
            d.indirect = 1'b1;
            d.guarded  = 1'b1;
            d.extra    = 1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/idx_ptr_fetch.sv
module idx_ptr_fetch
  import idx_agen_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic              rd_ack,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              last_beat,
  output logic [ADDR_W-1:0] word
);
  logic              low_phase;
  logic [BYTE_W-1:0] hi_byte;

  assign last_beat = rd_req && rd_ack && low_phase;
  assign word      = {hi_byte, rd_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req    <= 1'b0;
      rd_addr   <= '0;
      low_phase <= 1'b0;
      hi_byte   <= '0;
    end else if (go && !rd_req) begin
      rd_req    <= 1'b1;
      rd_addr   <= go_addr;
      low_phase <= 1'b0;
    end else if (rd_req && rd_ack) begin
      if (!low_phase) begin
        hi_byte   <= rd_data;
        rd_addr   <= rd_addr + 1'b1;
        low_phase <= 1'b1;
      end else begin
        rd_req    <= 1'b0;
        low_phase <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/idx_agen.sv
module idx_agen
  import idx_agen_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [BYTE_W-1:0]  postbyte,
  input  logic [BYTE_W-1:0]  ext0,
  input  logic [BYTE_W-1:0]  ext1,
  input  logic               restrict_mode,
  input  logic [ADDR_W-1:0]  x_reg,
  input  logic [ADDR_W-1:0]  y_reg,
  input  logic [ADDR_W-1:0]  sp_reg,
  input  logic [ADDR_W-1:0]  pc_reg,
  input  logic [BYTE_W-1:0]  acc_a,
  input  logic [BYTE_W-1:0]  acc_b,
  output logic               rd_req,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic               rd_ack,
  input  logic [BYTE_W-1:0]  rd_data,
  output logic               done,
  output logic [ADDR_W-1:0]  ea,
  output logic               reject,
  output logic [EXTRA_W-1:0] extra_cycles,
  output logic               wb_en,
  output logic [RSEL_W-1:0]  wb_sel,
  output logic [ADDR_W-1:0]  wb_val
);
  dec_t              dec;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] sum;
  logic              accept;
  logic              refuse;
  logic              fetch_go;
  logic              last_beat;
  logic [ADDR_W-1:0] ptr_word;

  idx_decode u_dec (
    .pb(postbyte), .e0(ext0), .e1(ext1), .a(acc_a), .b(acc_b), .d(dec)
  );

  always_comb begin
    case (dec.rsel)
      2'd0:    base = x_reg;
      2'd1:    base = y_reg;
      2'd2:    base = sp_reg;
      default: base = pc_reg;
    endcase
  end

  assign sum      = base + dec.offset;
  assign accept   = start && !rd_req;
  assign refuse   = restrict_mode && dec.guarded;
  assign fetch_go = accept && !refuse && dec.indirect;

  idx_ptr_fetch u_fetch (
    .clk(clk), .rst(rst), .go(fetch_go), .go_addr(sum),
    .rd_ack(rd_ack), .rd_data(rd_data), .rd_req(rd_req), .rd_addr(rd_addr),
    .last_beat(last_beat), .word(ptr_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done         <= 1'b0;
      ea           <= '0;
      reject       <= 1'b0;
      extra_cycles <= '0;
      wb_en        <= 1'b0;
      wb_sel       <= '0;
      wb_val       <= '0;
    end else begin
      done  <= 1'b0;
      wb_en <= 1'b0;
      if (last_beat) begin
        done         <= 1'b1;
        ea           <= ptr_word;
        reject       <= 1'b0;
        extra_cycles <= 1;
      end else if (accept && refuse) begin
        done         <= 1'b1;
        ea           <= '0;
        reject       <= 1'b1;
        extra_cycles <= '0;
      end else if (accept && !dec.indirect) begin
        done         <= 1'b1;
        reject       <= 1'b0;
        extra_cycles <= dec.extra;
        ea           <= (dec.writeback && dec.post) ? base : sum;
        wb_en        <= dec.writeback;
        wb_sel       <= dec.rsel;
        wb_val       <= sum;
      end
    end
  end
endmodule

// File: rtl/idx_agen_chk.sv
module idx_agen_chk
  import idx_agen_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               rd_req,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic               rd_ack,
  input logic               done,
  input logic [ADDR_W-1:0]  ea,
  input logic               reject,
  input logic [EXTRA_W-1:0] extra_cycles,
  input logic               wb_en
);
  assert_hold_req_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  assert_reject_clean_R8: assert property (@(posedge clk) disable iff (rst)
    (done && reject) |-> (ea == '0 && !wb_en && extra_cycles == '0));

  assert_no_req_on_reject_R8: assert property (@(posedge clk) disable iff (rst)
    (done && reject) |-> !rd_req);

  assert_wb_with_done_R2: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (done && !reject));

  assert_extra_range_R4: assert property (@(posedge clk) disable iff (rst)
    extra_cycles <= 1);

  assert_done_after_fetch_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_req) |-> (done && extra_cycles == 1));
endmodule

bind idx_agen idx_agen_chk u_chk (
  .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
  .done(done), .ea(ea), .reject(reject), .extra_cycles(extra_cycles),
  .wb_en(wb_en)
);

// File: tb/idx_agen_test.sv
module idx_agen_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        start = 0;
  logic [7:0]  postbyte = 0, ext0 = 0, ext1 = 0;
  logic        restrict_mode = 0;
  logic [15:0] x_reg = 16'h1000, y_reg = 16'h2000, sp_reg = 16'h3FF0, pc_reg = 16'h8000;
  logic [7:0]  acc_a = 8'hF0, acc_b = 8'h0F;
  logic        rd_req;
  logic [15:0] rd_addr;
  logic        rd_ack = 0;
  logic [7:0]  rd_data = 0;
  logic        done, reject, wb_en;
  logic [15:0] ea, wb_val;
  logic [1:0]  extra_cycles, wb_sel;

  int checks = 0, fails = 0;
  int beats = 0;
  logic [15:0] beat_addr [2];

  idx_agen uut (.*);

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // memory responder: ack after two wait cycles
  initial begin
    int wait_cnt = 0;
    forever begin
      @(negedge clk);
      if (rd_ack) begin
        rd_ack = 0;
        wait_cnt = 0;
      end else if (rd_req) begin
        wait_cnt++;
        if (wait_cnt == 2) begin
          rd_ack  = 1;
          rd_data = mem_byte(rd_addr);
          if (beats < 2) beat_addr[beats] = rd_addr;
          beats++;
        end
      end
    end
  end

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] reg_of(input logic [1:0] s);
    case (s)
      2'd0: return x_reg;
      2'd1: return y_reg;
      2'd2: return sp_reg;
      default: return pc_reg;
    endcase
  endfunction

  // expected results from the requirement text
  task automatic model(input logic [7:0] pb, e0, e1, input logic rs,
                       output logic [15:0] x_ea, output logic x_rej,
                       output logic x_wb, output logic [1:0] x_sel,
                       output logic [15:0] x_wbv, output logic [1:0] x_ex,
                       output logic x_ind, output logic [15:0] x_ptr);
    int off;
    logic [15:0] r;
    x_rej = 0; x_wb = 0; x_sel = 0; x_wbv = 0; x_ex = 0; x_ind = 0; x_ptr = 0;
    if (pb[5] == 0) begin
      off = pb[4] ? int'(pb[4:0]) - 32 : int'(pb[4:0]);
      x_ea = reg_of(pb[7:6]) + 16'(off);
    end else if (pb[7:6] != 2'b11) begin
      off = pb[3] ? int'(pb[3:0]) - 16 : int'(pb[3:0]) + 1;
      r = reg_of(pb[7:6]);
      x_wb = 1; x_sel = pb[7:6]; x_wbv = r + 16'(off);
      x_ea = pb[4] ? r : x_wbv;
    end else begin
      r = reg_of(pb[4:3]);
      if (pb[2:0] == 3'b011) begin
        x_ind = 1; x_ex = 1; x_ptr = r + {e0, e1};
      end else if (pb[2] == 0) begin
        x_ex = 1;
        off = pb[1] ? int'({e0, e1}) : (pb[0] ? int'(e0) - 256 : int'(e0));
        x_ea = r + 16'(off);
      end else begin
        case (pb[1:0])
          2'b00: x_ea = r + {8'h00, acc_a};
          2'b01: x_ea = r + {8'h00, acc_b};
          2'b10: x_ea = r + {acc_a, acc_b};
          default: begin x_ind = 1; x_ex = 1; x_ptr = r + {acc_a, acc_b}; end
        endcase
      end
      if (x_ind) x_ea = {mem_byte(x_ptr), mem_byte(x_ptr + 16'd1)};
      if (rs && (x_ind || pb[2] == 0)) begin
        x_rej = 1; x_ea = 0; x_ex = 0; x_ind = 0;
      end
    end
  endtask

  task automatic run(input string tag, input logic [7:0] pb, e0, e1, input logic rs);
    logic [15:0] x_ea, x_wbv, x_ptr;
    logic x_rej, x_wb, x_ind;
    logic [1:0] x_sel, x_ex;
    int n = 0;
    model(pb, e0, e1, rs, x_ea, x_rej, x_wb, x_sel, x_wbv, x_ex, x_ind, x_ptr);
    @(negedge clk);
    beats = 0;
    postbyte = pb; ext0 = e0; ext1 = e1; restrict_mode = rs; start = 1;
    @(negedge clk);
    start = 0;
    while (!done && n < 40) begin @(negedge clk); n++; end
    check(tag, "done", {15'd0, done}, 16'd1);
    if (!x_ind) check(tag, "latency", 16'(n), 16'd0);
    check(tag, "ea", ea, x_ea);
    check(tag, "reject", {15'd0, reject}, {15'd0, x_rej});
    check(tag, "extra", {14'd0, extra_cycles}, {14'd0, x_ex});
    check(tag, "wb_en", {15'd0, wb_en}, {15'd0, x_wb});
    if (x_wb) begin
      check(tag, "wb_sel", {14'd0, wb_sel}, {14'd0, x_sel});
      check(tag, "wb_val", wb_val, x_wbv);
    end
    check(tag, "beats", 16'(beats), x_ind ? 16'd2 : 16'd0);
    if (x_ind) begin
      check(tag, "ptr addr", beat_addr[0], x_ptr);
      check(tag, "ptr addr+1", beat_addr[1], x_ptr + 16'd1);
    end
    @(negedge clk);
    check(tag, "done pulse", {15'd0, done}, 16'd0);
  endtask

  task automatic t_reset;
    check("R11", "done", {15'd0, done}, 16'd0);
    check("R11", "rd_req", {15'd0, rd_req}, 16'd0);
    check("R11", "ea", ea, 16'd0);
    check("R11", "wb_en", {15'd0, wb_en}, 16'd0);
    check("R11", "reject", {15'd0, reject}, 16'd0);
  endtask

  task automatic t_const;
    run("R1", 8'h05, 8'h00, 8'h00, 0);
    run("R1", 8'h5F, 8'h00, 8'h00, 0);
    run("R1", 8'h90, 8'h00, 8'h00, 0);
    run("R1", 8'hC3, 8'h00, 8'h00, 0);
  endtask

  task automatic t_auto;
    run("R2", 8'h23, 8'h00, 8'h00, 0);
    run("R3", 8'h3F, 8'h00, 8'h00, 0);
    run("R2", 8'h67, 8'h00, 8'h00, 0);
    run("R3", 8'hB8, 8'h00, 8'h00, 0);
  endtask

  task automatic t_ext;
    run("R4", 8'hE0, 8'h7C, 8'h00, 0);
    run("R4", 8'hE9, 8'h10, 8'h00, 0);
    run("R4", 8'hF2, 8'h12, 8'h34, 0);
  endtask

  task automatic t_acc;
    run("R5", 8'hE4, 8'h00, 8'h00, 0);
    run("R5", 8'hED, 8'h00, 8'h00, 0);
    run("R5", 8'hF6, 8'h00, 8'h00, 0);
  endtask

  task automatic t_indirect;
    run("R6", 8'hE3, 8'h01, 8'h22, 0);
    run("R7", 8'hE7, 8'h00, 8'h00, 0);
  endtask

  task automatic t_wrap;
    run("R9", 8'hFE, 8'h00, 8'h00, 0);
    run("R9", 8'hFB, 8'h7F, 8'hFF, 0);
  endtask

  task automatic t_restrict;
    run("R8", 8'hE3, 8'h01, 8'h22, 1);
    run("R8", 8'hE0, 8'h7C, 8'h00, 1);
    run("R8", 8'hF2, 8'h12, 8'h34, 1);
    run("R8", 8'hE7, 8'h00, 8'h00, 1);
    run("R8", 8'h23, 8'h00, 8'h00, 1);
    run("R8", 8'hE4, 8'h00, 8'h00, 1);
  endtask

  task automatic t_hold;
    // R10: address captured at each acknowledge after wait states
    run("R10", 8'hFB, 8'h00, 8'h10, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_const;
    t_auto;
    t_ext;
    t_acc;
    t_indirect;
    t_wrap;
    t_restrict;
    t_hold;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule